// File: doc/BRIEF.md
# Quarter-Wave Sine Amplitude Generator

This block turns a binary phase angle into a signed sine amplitude in Q15 format. Only the rising quarter of one sine period is held in a table. The remaining three quarters of the wave are rebuilt from that quarter: the position inside the quarter is reflected for the second and fourth quarters, and the sign of the result is flipped for the third and fourth. Between two neighbouring table points, the output is found by a straight-line blend of those two points, weighted by the low bits of the phase.

A typical use is as the waveform stage after a phase accumulator in a digital synthesizer. The accumulator, with any modulation offset already added, drives the phase input together with a valid strobe. Each accepted phase gives one amplitude two clock cycles later, and a new phase can be accepted on every cycle. The table contents are computed by a constant function while the design is elaborated, so no initialization file is needed.

Top module: `quarter_sine_interp`

## Requirements
- R1: Every phase accepted with `in_valid` high produces a result with `out_valid` high exactly two clock cycles later. `out_valid` is low in every cycle that does not follow an accepted phase by exactly two cycles.
- R2: While `rst` is high and in the cycle after it, `out_valid` is 0 and `out_amp` is 0.
- R3: For a phase whose top 2 bits are 00 and whose low 6 bits are zero, with the middle 8 bits k, the output equals round(32767 * sin(k * pi / 512)).
- R4: For every phase value p, the output differs by at most 2 LSB from 32767 * sin(2 * pi * p / 65536).
- R5: Quarters 01 and 11 (the top 2 phase bits) reflect the 14-bit in-quarter position x to 16384 - x. As a result, the output at phase 0x4000 + x equals the output at 0x4000 - x for 0 < x < 16384.
- R6: Quarters 10 and 11 negate the result. The output at phase p + 0x8000 is exactly the negative of the output at p for p < 0x8000, and the output never reaches -32768.
- R7: Phases 0x0000, 0x4000, 0x8000 and 0xC000 give exactly 0, 32767, 0 and -32767. Stepping past the last table point uses a virtual point that holds 32767.
- R8: `out_amp` keeps its last value in every cycle in which `out_valid` is low.
- R9: Phases presented on consecutive cycles each produce a result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Phase input is valid in this cycle |
| in_phase | input | PHASE_W (16) | Phase angle; the full range covers one period |
| out_valid | output | 1 | Amplitude output is valid in this cycle |
| out_amp | output | AMP_W (16) | Signed Q15 sine amplitude |

## Verification
The bench builds the block with its default parameters: a 16-bit phase split into a 2-bit quarter, an 8-bit table index and a 6-bit blend fraction, with a 16-bit Q15 output. With a phase this narrow, every one of the 65536 angles can be streamed back to back and compared against a real-valued sine, so both the blend error and the reflection seams at the quarter boundaries are covered in full. Directed cases then pin the exact quarter-point values, the mirror and sign identities, the two-cycle latency and the hold behaviour.

// File: rtl/quarter_sine_interp.sv
module quarter_sine_interp #(
  parameter int PHASE_W = 16,
  parameter int IDX_W   = 8,
  parameter int AMP_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [PHASE_W-1:0]       in_phase,
  output logic                     out_valid,
  output logic signed [AMP_W-1:0]  out_amp
);

  localparam int QW     = PHASE_W - 2;
  localparam int FRAC_W = QW - IDX_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int MAXAMP = (1 << (AMP_W - 1)) - 1;
  localparam int PW     = AMP_W + FRAC_W + 2;
  localparam real PI    = 3.14159265358979323846;
  localparam logic [QW:0] QSPAN = (QW + 1)'(1 << QW);
  localparam logic signed [PW-1:0] HALF = PW'(1 << (FRAC_W - 1));

  function automatic logic signed [AMP_W-1:0] point(input int k);
    real x;
    int  r;
    x = real'(MAXAMP) * $sin(real'(k) * PI / (2.0 * real'(DEPTH)));
    r = $rtoi(x + 0.5);
    if (k >= DEPTH || r > MAXAMP) r = MAXAMP;
    return AMP_W'(r);
  endfunction

  logic signed [AMP_W-1:0] lut [DEPTH+1];

  for (genvar g = 0; g <= DEPTH; g++) begin : g_lut
    assign lut[g] = point(g);
  end

  logic [1:0]        quad;
  logic [QW:0]       pos, pos_m;
  logic [IDX_W:0]    idx, idx_n;
  logic [FRAC_W-1:0] frac;

  assign quad  = in_phase[PHASE_W-1 -: 2];
  assign pos   = {1'b0, in_phase[QW-1:0]};
  assign pos_m = quad[0] ? (QSPAN - pos) : pos;
  assign idx   = pos_m[QW -: IDX_W+1];
  assign frac  = pos_m[FRAC_W-1:0];
  assign idx_n = (idx == (IDX_W+1)'(DEPTH)) ? idx : idx + 1'b1;

  logic                    s1_v, s1_neg;
  logic signed [AMP_W-1:0] s1_a, s1_b;
  logic [FRAC_W-1:0]       s1_frac;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_neg  <= 1'b0;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_frac <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_neg  <= quad[1];
        s1_a    <= lut[idx];
        s1_b    <= lut[idx_n];
        s1_frac <= frac;
      end
    end
  end

  logic signed [PW-1:0]    diff_x, frac_x, prod, step;
  logic signed [AMP_W:0]   mag, res;

  assign diff_x = PW'(s1_b) - PW'(s1_a);
  assign frac_x = {{(PW-FRAC_W){1'b0}}, s1_frac};
  assign prod   = diff_x * frac_x;
  assign step   = (prod + HALF) >>> FRAC_W;
  assign mag    = (AMP_W+1)'(s1_a) + step[AMP_W:0];
  assign res    = s1_neg ? -mag : mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_amp   <= '0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) out_amp <= res[AMP_W-1:0];
    end
  end

endmodule

// File: rtl/quarter_sine_interp_chk.sv
module quarter_sine_interp_chk #(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [PHASE_W-1:0]      in_phase,
  input logic                    out_valid,
  input logic signed [AMP_W-1:0] out_amp
);

  logic [1:0] cyc;
  logic       v_d1, v_d2, h_d1, h_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc  <= '0;
      v_d1 <= 1'b0;
      v_d2 <= 1'b0;
      h_d1 <= 1'b0;
      h_d2 <= 1'b0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 1'b1;
      v_d1 <= in_valid;
      v_d2 <= v_d1;
      h_d1 <= in_phase[PHASE_W-1];
      h_d2 <= h_d1;
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (out_valid == v_d2));

  assert_reset_clear_R2: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_amp == '0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_amp != {1'b1, {(AMP_W-1){1'b0}}}));

  assert_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && out_valid) |-> (h_d2 ? (out_amp <= 0) : (out_amp >= 0)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd1 && !out_valid) |-> $stable(out_amp));

endmodule

bind quarter_sine_interp quarter_sine_interp_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
  .out_valid(out_valid), .out_amp(out_amp));

// File: tb/sim_quarter_sine_interp.sv
module sim_quarter_sine_interp;

  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_phase = '0;
  logic out_valid;
  logic signed [15:0] out_amp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  quarter_sine_interp u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(out_valid), .out_amp(out_amp));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ideal(input int p);
    return $rtoi(32767.0 * $sin(2.0 * PI * real'(p) / 65536.0) + ((p & 16'h8000) != 0 ? -0.5 : 0.5));
  endfunction

  task automatic apply(input int p, output int amp);
    @(negedge clk);
    in_valid = 1'b1;
    in_phase = p[15:0];
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R1", int'(out_valid), 1);
    amp = int'(out_amp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
    chk(out_amp == 16'sd0, "R2", int'(out_amp), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_amp == 16'sd0, "R2", int'(out_amp), 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1'b1;
    in_phase = 16'h1234;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R1", int'(out_valid), 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
  endtask

  task automatic t_exact();
    int a;
    apply(16'h0000, a); chk(a == 0,      "R7", a, 0);
    apply(16'h4000, a); chk(a == 32767,  "R7", a, 32767);
    apply(16'h8000, a); chk(a == 0,      "R7", a, 0);
    apply(16'hC000, a); chk(a == -32767, "R7", a, -32767);
  endtask

  task automatic t_table();
    int a, e;
    for (int k = 0; k < 256; k++) begin
      apply(k << 6, a);
      e = $rtoi(32767.0 * $sin(real'(k) * PI / 512.0) + 0.5);
      chk(a == e, "R3", a, e);
    end
  endtask

  task automatic t_mirror();
    int xs[5] = '{1, 37, 1000, 9001, 16383};
    int a, b;
    foreach (xs[i]) begin
      apply(16'h4000 + xs[i], a);
      apply(16'h4000 - xs[i], b);
      chk(a == b, "R5", a, b);
    end
  endtask

  task automatic t_negate();
    int ps[6] = '{5, 300, 8191, 16385, 20000, 32767};
    int a, b;
    foreach (ps[i]) begin
      apply(ps[i], a);
      apply(ps[i] + 16'h8000, b);
      chk(b == -a, "R6", b, -a);
    end
  endtask

  task automatic t_hold();
    int a;
    apply(16'h2222, a);
    for (int i = 0; i < 4; i++) begin
      in_phase = 16'(16'h9000 + i * 16'h0333);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
      chk(int'(out_amp) == a, "R8", int'(out_amp), a);
    end
  endtask

  task automatic t_sweep();
    int e, d;
    for (int i = 0; i < 65538; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        e = ideal(i - 2);
        d = int'(out_amp) - e;
        chk(out_valid == 1'b1, "R9", int'(out_valid), 1);
        chk(d <= 2 && d >= -2, "R4", int'(out_amp), e);
      end
      if (i < 65536) begin
        in_valid = 1'b1;
        in_phase = i[15:0];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_exact();
    t_table();
    t_mirror();
    t_negate();
    t_hold();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule